// File: doc/BRIEF.md
# Grouped Input Debouncer with Programmable Tick

This block filters a wide bank of slow digital inputs such as contact closures or relay states. It declares a change on a channel only after the new level has held steady for a programmable time. Channels are organised in groups. Each group shares one tick generator, so the filter window is set per group and never per channel. The tick comes from a single free-running binary divider per group. A 5-bit rate setting picks which power-of-two stage of that divider produces the tick.

Each raw input first passes a two-stage synchronizer. A small per-channel counter then tracks how many ticks in a row the synchronized level has differed from the filtered output. On the fourth such tick the output takes the new level. Any return to the old level before that point discards the count. Writing a new rate setting to a group restarts that group's divider and discards the pending counts of that group only.

Top module: `input_debounce_bank`

## Requirements
- R1: While reset is high, every bit of `clean_out` is 0 on the cycle after the reset edge, every stability count is cleared, and each group's stored rate setting is 0.
- R2: A channel's output takes the synchronized input's new level only on the fourth consecutive tick during which that level differed from the output. It changes on no other cycle. Measured in clock edges from the edge that first samples the new raw level, the latency lies between 3P+2 and 4P+1, where P is the tick period of the channel's group.
- R3: A raw pulse held for fewer than P cycles, which therefore spans at most one tick, never changes the output.
- R4: For a 5-bit setting n from 2 to 31, the group's tick period is P = 2^(n-2+BASE_LOG2) clock cycles. Each increment of n doubles the period. After a restart, the first tick comes P cycles later.
- R5: Setting 0 gives the same period as setting 2, and setting 1 gives the same period as setting 3.
- R6: Channel c belongs to group c / CH_PER_GRP. Group g's setting is read from `grp_setting[5g+4:5g]`, and it alone governs the timing of that group's channels.
- R7: When a group's setting input differs from its stored value, that group's divider restarts at zero and all of its channels' stability counts clear. The other groups are not disturbed.
- R8: A falling input is filtered with the same four-tick rule and the same latency window as a rising input.
- R9: No stability count ever exceeds 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_setting | input | N_GRP*5 | Rate setting per group; group g occupies bits [5g+4:5g] |
| raw_in | input | N_GRP*CH_PER_GRP | Unfiltered, asynchronous channel inputs |
| clean_out | output | N_GRP*CH_PER_GRP | Debounced channel levels |

## Verification
The bench builds the block with two groups of eight channels and BASE_LOG2 = 1, so setting 2 ticks every 2 cycles and setting 5 every 16. With these values the full four-tick window, setting restarts in the middle of a count, and independent group timing can all be reached in a few hundred cycles each. A cycle-level model of the requirements is compared with every output on every cycle under random toggles and random setting changes. Directed runs check latency windows for settings 0, 1, 2, 3 and 5, short glitches, falling edges, and a restart in the middle of a count. Settings above 6 are not run to completion, since their windows exceed the run length.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    localparam int SET_W      = 5;
    localparam int MIN_SET    = 2;
    localparam int MAX_SET    = 31;
    localparam int HOLD_TICKS = 4;
    localparam int STAB_W     = 3;

    typedef logic [SET_W-1:0]  rate_sel_t;
    typedef logic [STAB_W-1:0] stab_cnt_t;

    typedef struct packed {
        logic tick;
        logic restart;
    } grp_ctl_t;

    typedef struct packed {
        logic      sync1;
        logic      sync2;
        logic      level;
        stab_cnt_t run;
    } chan_state_t;

    // Settings below the minimum alias upward by two.
    function automatic rate_sel_t eff_setting(rate_sel_t s);
        return (s < rate_sel_t'(MIN_SET)) ? s + rate_sel_t'(MIN_SET) : s;
    endfunction

    // Width of the all-ones divider slice that marks a tick.
    function automatic logic [6:0] tick_span(rate_sel_t s, int unsigned base);
        return 7'(eff_setting(s)) - 7'(MIN_SET) + 7'(base);
    endfunction

endpackage

// File: rtl/dbn_prescaler.sv
module dbn_prescaler
    import dbn_pkg::*;
#(
    parameter int BASE_LOG2 = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  rate_sel_t setting,
    output grp_ctl_t  ctl
);
    localparam int CNT_W = BASE_LOG2 + (MAX_SET - MIN_SET) + 1;

    rate_sel_t        set_q;
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] slice_mask;
    logic [6:0]       span;

    always_comb begin
        span        = tick_span(set_q, BASE_LOG2);
        slice_mask  = (CNT_W'(1) << span) - CNT_W'(1);
        ctl.restart = (setting != set_q);
        ctl.tick    = ((div_q & slice_mask) == slice_mask) && !ctl.restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
            div_q <= '0;
        end else if (ctl.restart) begin
            set_q <= setting;
            div_q <= '0;
        end else begin
            div_q <= div_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dbn_channel.sv
module dbn_channel
    import dbn_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    input  grp_ctl_t  ctl,
    output logic      level,
    output stab_cnt_t run_cnt
);
    chan_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.sync1 <= raw;
            st.sync2 <= st.sync1;
            if (ctl.restart) begin
                st.run <= '0;
            end else if (st.sync2 == st.level) begin
                st.run <= '0;
            end else if (ctl.tick) begin
                if (st.run == stab_cnt_t'(HOLD_TICKS - 1)) begin
                    st.level <= st.sync2;
                    st.run   <= '0;
                end else begin
                    st.run <= st.run + stab_cnt_t'(1);
                end
            end
        end
    end

    assign level   = st.level;
    assign run_cnt = st.run;

endmodule

// File: rtl/input_debounce_bank.sv
module input_debounce_bank
    import dbn_pkg::*;
#(
    parameter int N_GRP      = 2,
    parameter int CH_PER_GRP = 32,
    parameter int BASE_LOG2  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_GRP*SET_W-1:0]        grp_setting,
    input  logic [N_GRP*CH_PER_GRP-1:0]   raw_in,
    output logic [N_GRP*CH_PER_GRP-1:0]   clean_out
);
    localparam int N_CH = N_GRP * CH_PER_GRP;

    grp_ctl_t                grp_ctl [N_GRP];
    logic [N_GRP-1:0]        grp_tick;
    logic [N_GRP-1:0]        grp_restart;
    logic [STAB_W*N_CH-1:0]  stab_flat;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        dbn_prescaler #(.BASE_LOG2(BASE_LOG2)) u_div (
            .clk     (clk),
            .rst     (rst),
            .setting (grp_setting[g*SET_W +: SET_W]),
            .ctl     (grp_ctl[g])
        );
        assign grp_tick[g]    = grp_ctl[g].tick;
        assign grp_restart[g] = grp_ctl[g].restart;

        for (genvar k = 0; k < CH_PER_GRP; k++) begin : g_ch
            localparam int C = g * CH_PER_GRP + k;
            dbn_channel u_ch (
                .clk     (clk),
                .rst     (rst),
                .raw     (raw_in[C]),
                .ctl     (grp_ctl[g]),
                .level   (clean_out[C]),
                .run_cnt (stab_flat[C*STAB_W +: STAB_W])
            );
        end
    end

endmodule

// File: rtl/dbn_checker.sv
module dbn_checker
    import dbn_pkg::*;
#(
    parameter int N_GRP      = 2,
    parameter int CH_PER_GRP = 32,
    parameter int BASE_LOG2  = 2
) (
    input logic                               clk,
    input logic                               rst,
    input logic [N_GRP*CH_PER_GRP-1:0]        clean_out,
    input logic [N_GRP-1:0]                   grp_tick,
    input logic [N_GRP-1:0]                   grp_restart,
    input logic [STAB_W*N_GRP*CH_PER_GRP-1:0] stab_flat
);
    localparam int GW = STAB_W * CH_PER_GRP;

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            p_reset_clear_r1: assert (clean_out == '0 && stab_flat == '0)
                else $error("R1: state not cleared after reset");
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        p_change_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$stable(clean_out[g*CH_PER_GRP +: CH_PER_GRP]))
                |-> $past(grp_tick[g]))
            else $error("R2: output moved without a tick");

        p_restart_clears_r7: assert property (@(posedge clk) disable iff (rst)
            grp_restart[g] |=> (stab_flat[g*GW +: GW] == '0))
            else $error("R7: counts survived a restart");

        if (BASE_LOG2 > 0) begin : g_gap
            p_no_early_tick_r4: assert property (@(posedge clk) disable iff (rst)
                grp_restart[g] |=> !grp_tick[g])
                else $error("R4: tick right after restart");
        end
    end

    for (genvar c = 0; c < N_GRP * CH_PER_GRP; c++) begin : g_cnt
        p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
            stab_flat[c*STAB_W +: STAB_W] <= stab_cnt_t'(HOLD_TICKS - 1))
            else $error("R9: stability count overflow");
    end

endmodule

bind input_debounce_bank dbn_checker #(
    .N_GRP      (N_GRP),
    .CH_PER_GRP (CH_PER_GRP),
    .BASE_LOG2  (BASE_LOG2)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clean_out   (clean_out),
    .grp_tick    (grp_tick),
    .grp_restart (grp_restart),
    .stab_flat   (stab_flat)
);

// File: tb/input_debounce_bank_tb.sv
module input_debounce_bank_tb;
    localparam int NG   = 2;
    localparam int CPG  = 8;
    localparam int BASE = 1;
    localparam int NCH  = NG * CPG;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NG*5-1:0]  grp_setting = '0;
    logic [NCH-1:0]   raw_in = '0;
    logic [NCH-1:0]   clean_out;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 0;
    bit    model_chk = 0;
    string phase_req = "R2";

    always #5 clk = ~clk;

    input_debounce_bank #(.N_GRP(NG), .CH_PER_GRP(CPG), .BASE_LOG2(BASE)) u_dut (
        .clk(clk), .rst(rst), .grp_setting(grp_setting),
        .raw_in(raw_in), .clean_out(clean_out)
    );

    function automatic int eff(int s);
        return (s < 2) ? s + 2 : s;
    endfunction

    function automatic int period(int s);
        return 1 << (eff(s) - 2 + BASE);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Reference model built from the requirements
    int              m_s1 [NCH];
    int              m_s2 [NCH];
    int              m_out[NCH];
    int              m_cnt[NCH];
    longint unsigned m_div[NG];
    int              m_set[NG];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_s1[c] = 0; m_s2[c] = 0; m_out[c] = 0; m_cnt[c] = 0;
            end
            for (int g = 0; g < NG; g++) begin
                m_div[g] = 0; m_set[g] = 0;
            end
        end else begin
            bit chg[NG];
            bit tk[NG];
            for (int g = 0; g < NG; g++) begin
                longint unsigned msk;
                chg[g] = (int'(grp_setting[g*5 +: 5]) != m_set[g]);
                msk = (64'd1 << (eff(m_set[g]) - 2 + BASE)) - 64'd1;
                tk[g] = !chg[g] && ((m_div[g] & msk) == msk);
            end
            for (int c = 0; c < NCH; c++) begin
                int g;
                g = c / CPG;
                if (chg[g]) m_cnt[c] = 0;
                else if (m_s2[c] == m_out[c]) m_cnt[c] = 0;
                else if (tk[g]) begin
                    if (m_cnt[c] == 3) begin
                        m_out[c] = m_s2[c]; m_cnt[c] = 0;
                    end else m_cnt[c]++;
                end
                m_s2[c] = m_s1[c];
                m_s1[c] = int'(raw_in[c]);
            end
            for (int g = 0; g < NG; g++) begin
                if (chg[g]) begin
                    m_div[g] = 0;
                    m_set[g] = int'(grp_setting[g*5 +: 5]);
                end else m_div[g]++;
            end
        end
    end

    always @(negedge clk) begin
        if (model_chk && !rst) begin
            logic [NCH-1:0] exp_v;
            for (int c = 0; c < NCH; c++) exp_v[c] = m_out[c][0];
            check(clean_out == exp_v, phase_req, longint'(clean_out), longint'(exp_v));
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic set_grp(int g, int s);
        @(negedge clk);
        grp_setting[g*5 +: 5] = 5'(s);
    endtask

    // R2/R4/R5/R8 latency window from the edge that samples the new level
    task automatic latency(int ch, int s, bit rise, string req);
        int p;
        int k;
        p = period(s);
        set_grp(ch / CPG, s);
        raw_in[ch] = !rise;
        repeat (5 * p + 8) @(negedge clk);
        check(clean_out[ch] == !rise, req, clean_out[ch], !rise);
        raw_in[ch] = rise;
        k = 0;
        while (clean_out[ch] != rise && k < 8 * p + 10) begin
            @(negedge clk);
            k++;
        end
        check(k >= 3 * p + 2 && k <= 4 * p + 1, req, k, 3 * p + 2);
    endtask

    initial begin
        int seed;
        seed = 32'h1d2b;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        // R1: outputs cleared while in reset
        check(clean_out == '0, "R1", clean_out, 0);
        rst = 0;
        @(negedge clk);
        check(clean_out == '0, "R1", clean_out, 0);

        // R4 and R2: several settings, rising edges
        latency(0, 2, 1'b1, "R4");
        latency(1, 3, 1'b1, "R4");
        latency(2, 5, 1'b1, "R2");
        // R5: aliases
        latency(3, 0, 1'b1, "R5");
        latency(4, 1, 1'b1, "R5");
        // R8: falling edges
        latency(2, 3, 1'b0, "R8");
        latency(9, 2, 1'b0, "R8");

        // R3: glitch shorter than one period
        set_grp(0, 3);
        raw_in = '0;
        repeat (40) @(negedge clk);
        raw_in[5] = 1'b1;
        repeat (period(3) - 1) @(negedge clk);
        raw_in[5] = 1'b0;
        repeat (6 * period(3)) @(negedge clk);
        check(clean_out[5] == 1'b0, "R3", clean_out[5], 0);

        // R6: groups at different rates
        set_grp(0, 2);
        set_grp(1, 7);
        raw_in = '0;
        repeat (300) @(negedge clk);
        raw_in = '1;
        repeat (4 * period(2) + 4) @(negedge clk);
        check(clean_out[CPG-1:0] == '1, "R6", clean_out[CPG-1:0], 8'hff);
        check(clean_out[NCH-1:CPG] == '0, "R6", clean_out[NCH-1:CPG], 0);

        // R7: restart in mid count delays the output
        set_grp(0, 4);
        raw_in = '0;
        repeat (300) @(negedge clk);
        raw_in[0] = 1'b1;
        repeat (2 * period(4)) @(negedge clk);
        grp_setting[4:0] = 5'd5;
        repeat (3 * period(5) + period(5) / 2) @(negedge clk);
        check(clean_out[0] == 1'b0, "R7", clean_out[0], 0);
        repeat (period(5)) @(negedge clk);
        check(clean_out[0] == 1'b1, "R7", clean_out[0], 1);

        // Random phase against the model (R2, R6, R7)
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        model_chk = 1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            phase_req = (i % 2 == 0) ? "R2" : "R7";
            if ($urandom % 97 == 0)
                grp_setting[($urandom % NG) * 5 +: 5] = 5'($urandom % 6);
            if ($urandom % 6 == 0)
                raw_in[$urandom % NCH] ^= 1'b1;
            if ($urandom % 40 == 0)
                raw_in ^= NCH'($urandom);
        end
        model_chk = 0;
        @(negedge clk);
        finish_run();
    end

endmodule